// File: doc/BRIEF.md
# Selectable Timebase and Range Gating

This block turns a 10 MHz reference clock into a qualified count-enable stream for a period, pulse-width or event counter. A free-running prescaler is built from cascaded decimal digit stages. It produces single-cycle ticks at 100 ns, 10 µs and 10 ms. A two-bit range select picks one of these ticks, and the measurement gate qualifies it, so a downstream counter advances only while the gate is high. When the gate falls, counting stops and the downstream count holds.

The fourth range is totalize. In that position the timebase is not used, and each gate-start strobe gives exactly one enable, so the downstream counter counts events. The block also drives a one-hot unit indicator, a decimal-point position and a totalize flag. These let the display side show microseconds (0 to 9999.9), milliseconds (0 to 999.99), seconds (0 to 999.99) or a plain event count.

Range select encoding: 0 selects the 100 ns range, 1 the 10 µs range, 2 the 10 ms range and 3 totalize. The division ratios are 10^`B_DIGITS` and 10^`C_DIGITS` reference cycles, with defaults of 100 and 100000.

Top module: `timebase_range_gate`

## Requirements
- R1: After reset the prescaler starts from zero, so in range 1 with the gate high the first enable appears in the 99th cycle after reset is released (10^B_DIGITS - 1).
- R2: In range 0 with the gate high, `cnt_en` is high in every cycle.
- R3: In range 1 with the gate held high, consecutive enables are exactly 10^B_DIGITS cycles apart, and each prescaler digit stays within 0 to 9.
- R4: In range 2 with the gate held high, consecutive enables are exactly 10^C_DIGITS cycles apart.
- R5: In ranges 0, 1 and 2, `cnt_en` is low in every cycle in which `gate` is low.
- R6: In range 3, `cnt_en` equals `gate_start`. Each strobe gives one enable, and a gate held high without strobes gives none.
- R7: `range_led` is one-hot, and its set bit index equals `range_sel` (bit 0 = µs, bit 1 = ms, bit 2 = s, bit 3 = totalize).
- R8: `dp_pos` gives the number of fractional display digits: 1 in range 0, 2 in ranges 1 and 2, and 0 in range 3.
- R9: `totalize` is high exactly when `range_sel` is 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 10 MHz reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| range_sel | input | 2 | Range select (0 µs, 1 ms, 2 s, 3 totalize) |
| gate | input | 1 | Measurement gate level |
| gate_start | input | 1 | Single-cycle strobe at the gate's opening |
| cnt_en | output | 1 | Count-enable pulse stream for the downstream counter |
| range_led | output | 4 | One-hot unit indicator |
| dp_pos | output | 2 | Number of fractional digits to display |
| totalize | output | 1 | High in the event-counting range |

## Verification
The assertions check on every cycle that:
- no enable escapes a low gate in a timed range;
- no enable appears without a strobe in totalize;
- the 10 µs range never gives enables in back-to-back cycles;
- every prescaler digit stays decimal;
- the unit indicator stays one-hot.

The exact tick spacing in the two divided ranges can only be shown by the bench's scenarios, which measure the distance between pulses. The same holds for the first-tick latency after reset, the per-event count in totalize and the decimal-point and flag decoding for each range.

// File: rtl/timebase_range_gate.sv
module timebase_range_gate #(
  parameter int B_DIGITS = 2,
  parameter int C_DIGITS = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] range_sel,
  input  logic       gate,
  input  logic       gate_start,
  output logic       cnt_en,
  output logic [3:0] range_led,
  output logic [1:0] dp_pos,
  output logic       totalize
);
  localparam int ND = C_DIGITS;

  logic [ND:0] step;
  logic        tick;

  assign step[0] = 1'b1;

  genvar i;
  generate
    for (i = 0; i < ND; i++) begin : g_dec
      logic [3:0] d;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)       d <= '0;
        else if (step[i]) d <= (d == 4'd9) ? 4'd0 : d + 4'd1;
      assign step[i+1] = step[i] & (d == 4'd9);

      assert_digit_decimal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        d <= 4'd9);
    end
  endgenerate

  always_comb begin
    case (range_sel)
      2'd0:    tick = 1'b1;
      2'd1:    tick = step[B_DIGITS];
      2'd2:    tick = step[ND];
      default: tick = 1'b0;
    endcase
  end

  assign totalize  = (range_sel == 2'd3);
  assign cnt_en    = totalize ? gate_start : (gate & tick);
  assign range_led = 4'b0001 << range_sel;
  assign dp_pos    = (range_sel == 2'd0) ? 2'd1 : (totalize ? 2'd0 : 2'd2);

  assert_gate_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (range_sel != 2'd3 && !gate) |-> !cnt_en);

  assert_event_needs_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (range_sel == 2'd3 && !gate_start) |-> !cnt_en);

  assert_ms_not_back_to_back_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (range_sel == 2'd1 && cnt_en) |=> (range_sel != 2'd1 || !cnt_en));

  assert_led_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(range_led) == 1);
endmodule

// File: tb/timebase_range_gate_test.sv
module timebase_range_gate_test;
  localparam int BD = 2;
  localparam int CD = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] range_sel = 2'd0;
  logic gate = 1'b0, gate_start = 1'b0;
  logic cnt_en, totalize;
  logic [3:0] range_led;
  logic [1:0] dp_pos;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  timebase_range_gate #(.B_DIGITS(BD), .C_DIGITS(CD)) uut (
    .clk(clk), .rst_n(rst_n), .range_sel(range_sel), .gate(gate),
    .gate_start(gate_start), .cnt_en(cnt_en), .range_led(range_led),
    .dp_pos(dp_pos), .totalize(totalize));

  always #10 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick_cycle();
    @(negedge clk);
    #5;
  endtask

  task automatic count_en(input int n, output int c);
    c = 0;
    for (int k = 0; k < n; k++) begin
      tick_cycle();
      if (cnt_en) c++;
    end
  endtask

  task automatic gap_to_next(output int g);
    g = 0;
    for (int k = 0; k < 5000; k++) begin
      tick_cycle();
      g++;
      if (cnt_en) break;
    end
  endtask

  task automatic test_reset_latency();
    int g;
    range_sel = 2'd1;
    gate = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    gap_to_next(g);
    check("R1 first tick after reset", g, 99);
  endtask

  task automatic test_range_a();
    int c;
    @(negedge clk);
    range_sel = 2'd0;
    gate = 1'b1;
    count_en(37, c);
    check("R2 enables per cycle", c, 37);
    check("R8 dp range0", dp_pos, 1);
    check("R7 led range0", range_led, 4'b0001);
    check("R9 flag range0", totalize, 0);
    @(negedge clk);
    gate = 1'b0;
    count_en(50, c);
    check("R5 gate low range0", c, 0);
  endtask

  task automatic test_range_b();
    int g, c;
    @(negedge clk);
    range_sel = 2'd1;
    gate = 1'b1;
    gap_to_next(g);
    for (int p = 0; p < 3; p++) begin
      gap_to_next(g);
      check("R3 spacing range1", g, 100);
    end
    count_en(1000, c);
    check("R3 count over 1000", c, 10);
    check("R8 dp range1", dp_pos, 2);
    check("R7 led range1", range_led, 4'b0010);
    @(negedge clk);
    gate = 1'b0;
    count_en(300, c);
    check("R5 gate low range1", c, 0);
  endtask

  task automatic test_range_c();
    int g;
    @(negedge clk);
    range_sel = 2'd2;
    gate = 1'b1;
    gap_to_next(g);
    gap_to_next(g);
    check("R4 spacing range2", g, 1000);
    gap_to_next(g);
    check("R4 spacing range2 again", g, 1000);
    check("R8 dp range2", dp_pos, 2);
    check("R7 led range2", range_led, 4'b0100);
    check("R9 flag range2", totalize, 0);
  endtask

  task automatic test_totalize();
    int c, ev;
    @(negedge clk);
    range_sel = 2'd3;
    gate = 1'b1;
    count_en(400, c);
    check("R6 no strobe no count", c, 0);
    check("R7 led range3", range_led, 4'b1000);
    check("R8 dp range3", dp_pos, 0);
    check("R9 flag range3", totalize, 1);
    ev = 0;
    for (int e = 0; e < 5; e++) begin
      @(negedge clk);
      gate_start = 1'b1;
      gate = 1'b1;
      #5;
      if (cnt_en) ev++;
      @(negedge clk);
      gate_start = 1'b0;
      count_en(7, c);
      ev += c;
      @(negedge clk);
      gate = 1'b0;
    end
    check("R6 one count per event", ev, 5);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset_latency();
    test_range_a();
    test_range_b();
    test_range_c();
    test_totalize();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule